// File: doc/BRIEF.md
# Per-Pixel Gain Steering Controller

This block picks, for every pixel, one of four programmable 6-bit gain words and presents it to a per-pixel gain stage in an image-sensor front end. Each gain word is a two's-complement code: the most negative code gives the lowest gain, the most positive code gives the highest, and zero sits just above the nominal midpoint. The block follows a colour-filter pattern. The choice depends on whether the pixel is even or odd within its line, whether the line is even or odd, or which field is current. It tracks these with a horizontal and a vertical sync pulse.

Software loads four gain registers and a control register through a simple write port. All written values sit in a shadow bank. They are copied into the working bank only at a horizontal sync edge, so a line never changes gain part-way through. On each pixel strobe the block registers the selected gain code and its 2-bit index. When steering is disabled, a fixed code standing for the nominal midpoint gain is output instead.

Top module: `pixgain_steer`

## Requirements
- R1: After reset the outputs are 0, all gain registers are 0, steering is disabled with mode 0, and the pixel, line and field parities are 0. After reset, a field-mode setup followed by a single HD edge and no VD edge therefore selects index 0 and then index 1.
- R2: `gainCode` and `gainIdx` change only on a clock edge at which `pixStrobe` is high. At any other time they hold their value.
- R3: While the working enable bit is low, a strobed pixel outputs code 6'b111111 with index 0.
- R4: With steering enabled and a mode code other than 1 or 2 (0, 3, 4, 5, 6, 7), every pixel selects index 0 (Gain0).
- R5: Mode 1 (mosaic) selects index {line parity, pixel parity}. The pixel parity toggles after each strobed pixel.
- R6: Mode 2 (field-selected) selects index {field flag, pixel parity}.
- R7: An HD edge is a cycle in which `hsync` is high after having been low in the previous cycle. An HD edge clears the pixel parity and toggles the line parity. A pixel strobed in that same cycle is the first pixel of the new line.
- R8: A VD edge (the same rule, applied to `vsync`) clears the line parity and toggles the field flag. A VD edge takes precedence over an HD edge in the same cycle. A VD edge alone leaves the pixel parity unchanged.
- R9: `wrAddr` 0 to 3 write Gain0 to Gain3. Address 4 writes the control register, with `wrData[3]` as the enable bit and `wrData[2:0]` as the mode. Addresses 5 to 7 are ignored. Written values reach the working bank only at the next HD edge, and a pixel strobed in that edge cycle already uses them.
- R10: For an enabled pixel, `gainCode` equals the 6-bit content of the working gain register at `gainIdx`, passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixStrobe | input | 1 | Pixel valid; one gain selection per high cycle |
| hsync | input | 1 | Horizontal sync level; rising edge starts a line |
| vsync | input | 1 | Vertical sync level; rising edge starts a field |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 3 | Register address (0-3 gains, 4 control) |
| wrData | input | 6 | Write data |
| gainCode | output | 6 | Selected two's-complement gain code |
| gainIdx | output | 2 | Index of the selected gain register |

## Verification
Several properties are checked on every cycle:
- the outputs hold between strobes;
- the code is forced to all-ones whenever the working enable is low;
- the single-gain fallback always reports index 0;
- an enabled code always matches the working register at the reported index;
- the first pixel after an HD edge always takes the even gain of its pair.

Other behaviour depends on history across lines and fields, and only the bench scenarios can show it. This covers the actual line, field and pixel parity sequences, VD taking precedence over HD, and writes staying invisible until the next HD edge. The bench compares each of these against its own model of the steering pattern.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  localparam int NUM_GAINS = 4;
  localparam int IDX_W     = $clog2(NUM_GAINS);
  localparam int MODE_W    = 3;
  localparam int EN_BIT    = 3;

  localparam logic [MODE_W-1:0] MODE_MOSAIC = 3'd1;
  localparam logic [MODE_W-1:0] MODE_FIELD  = 3'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBank;  // HD edge: copy shadow to working bank
    logic pixValid;  // pixel strobe this cycle
    logic pixPar;    // effective pixel parity
    logic linePar;   // effective line parity
    logic fieldPar;  // effective field flag
  } steerStrobe_t;
endpackage

// File: rtl/pgs_steer_ctrl.sv
module pgs_steer_ctrl
  import pgs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pixStrobe,
  input  logic         hsync,
  input  logic         vsync,
  output steerStrobe_t strb
);
  logic hPrev, vPrev;
  logic pixParQ, lineParQ, fieldParQ;
  logic hEdge, vEdge;

  assign hEdge = hsync & ~hPrev;
  assign vEdge = vsync & ~vPrev;

  always_comb begin
    strb.loadBank = hEdge;
    strb.pixValid = pixStrobe;
    strb.pixPar   = hEdge ? 1'b0 : pixParQ;
    if (vEdge)      strb.linePar = 1'b0;
    else if (hEdge) strb.linePar = ~lineParQ;
    else            strb.linePar = lineParQ;
    strb.fieldPar = vEdge ? ~fieldParQ : fieldParQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hPrev     <= 1'b0;
      vPrev     <= 1'b0;
      pixParQ   <= 1'b0;
      lineParQ  <= 1'b0;
      fieldParQ <= 1'b0;
    end else begin
      hPrev     <= hsync;
      vPrev     <= vsync;
      pixParQ   <= pixStrobe ? ~strb.pixPar : strb.pixPar;
      lineParQ  <= strb.linePar;
      fieldParQ <= strb.fieldPar;
    end
  end
endmodule

// File: rtl/pgs_gain_path.sv
module pgs_gain_path
  import pgs_pkg::*;
#(
  parameter int GAIN_W = 6,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [GAIN_W-1:0]             wrData,
  input  steerStrobe_t                  strb,
  output logic [GAIN_W-1:0]             gainCode,
  output logic [IDX_W-1:0]              gainIdx,
  output logic                          actEnOut,
  output logic [MODE_W-1:0]             actModeOut,
  output logic [NUM_GAINS*GAIN_W-1:0]   actGainFlat
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_GAINS);

  logic [GAIN_W-1:0] shGain   [NUM_GAINS];
  logic [GAIN_W-1:0] actGain  [NUM_GAINS];
  logic [GAIN_W-1:0] bankGain [NUM_GAINS];
  logic              shEn, actEn, bankEn;
  logic [MODE_W-1:0] shMode, actMode, bankMode;
  logic [IDX_W-1:0]  selIdx;

  for (genvar g = 0; g < NUM_GAINS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shGain[g]  <= '0;
        actGain[g] <= '0;
      end else begin
        if (strb.loadBank)                         actGain[g] <= shGain[g];
        if (wrEn && wrAddr == ADDR_W'(g))          shGain[g]  <= wrData;
      end
    end
    assign bankGain[g] = strb.loadBank ? shGain[g] : actGain[g];
    assign actGainFlat[g*GAIN_W +: GAIN_W] = actGain[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shEn    <= 1'b0;
      shMode  <= '0;
      actEn   <= 1'b0;
      actMode <= '0;
    end else begin
      if (strb.loadBank) begin
        actEn   <= shEn;
        actMode <= shMode;
      end
      if (wrEn && wrAddr == CTRL_ADDR) begin
        shEn   <= wrData[EN_BIT];
        shMode <= wrData[MODE_W-1:0];
      end
    end
  end

  assign bankEn   = strb.loadBank ? shEn   : actEn;
  assign bankMode = strb.loadBank ? shMode : actMode;

  always_comb begin
    selIdx = '0;
    if (bankEn) begin
      case (bankMode)
        MODE_MOSAIC: selIdx = {strb.linePar,  strb.pixPar};
        MODE_FIELD:  selIdx = {strb.fieldPar, strb.pixPar};
        default:     selIdx = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gainCode <= '0;
      gainIdx  <= '0;
    end else if (strb.pixValid) begin
      gainIdx  <= selIdx;
      gainCode <= bankEn ? bankGain[selIdx] : '1;
    end
  end

  assign actEnOut   = actEn;
  assign actModeOut = actMode;
endmodule

// File: rtl/pixgain_steer.sv
module pixgain_steer
  import pgs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixStrobe,
  input  logic       hsync,
  input  logic       vsync,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [5:0] wrData,
  output logic [5:0] gainCode,
  output logic [1:0] gainIdx
);
  localparam int GAIN_W = 6;
  localparam int ADDR_W = 3;

  steerStrobe_t                strb;
  logic                        actEn;
  logic [MODE_W-1:0]           actMode;
  logic [NUM_GAINS*GAIN_W-1:0] actGainFlat;

  pgs_steer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pixStrobe(pixStrobe),
    .hsync(hsync), .vsync(vsync), .strb(strb)
  );

  pgs_gain_path #(.GAIN_W(GAIN_W), .ADDR_W(ADDR_W)) path_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .gainCode(gainCode), .gainIdx(gainIdx),
    .actEnOut(actEn), .actModeOut(actMode), .actGainFlat(actGainFlat)
  );
endmodule

// File: rtl/pgs_steer_chk.sv
module pgs_steer_chk
  import pgs_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        pixStrobe,
  input logic        hsync,
  input logic [5:0]  gainCode,
  input logic [1:0]  gainIdx,
  input logic        actEn,
  input logic [2:0]  actMode,
  input logic [23:0] actGainFlat
);
  logic pastValid, hPrevC, firstPix;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pastValid <= 1'b0;
      hPrevC    <= 1'b0;
      firstPix  <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      hPrevC    <= hsync;
      firstPix  <= pixStrobe && hsync && !hPrevC;
    end
  end

  // R2: outputs hold when no pixel was strobed
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(pixStrobe)) |-> ($stable(gainCode) && $stable(gainIdx)));

  // R3: disabled steering gives the fixed midpoint code
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(pixStrobe) && !actEn) |-> (gainCode == 6'h3F && gainIdx == 2'd0));

  // R4: fallback modes always pick Gain0
  p_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(pixStrobe) && actEn && actMode != MODE_MOSAIC && actMode != MODE_FIELD)
      |-> (gainIdx == 2'd0));

  // R10: enabled code equals the working register at the reported index
  p_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(pixStrobe) && actEn) |-> (gainCode == actGainFlat[gainIdx*6 +: 6]));

  // R7: first pixel of a line takes the even gain of its pair
  p_newline_r7: assert property (@(posedge clk) disable iff (!rstN)
    (firstPix && actEn) |-> (gainIdx[0] == 1'b0));
endmodule

bind pixgain_steer pgs_steer_chk chk_i (
  .clk(clk), .rstN(rstN), .pixStrobe(pixStrobe), .hsync(hsync),
  .gainCode(gainCode), .gainIdx(gainIdx),
  .actEn(actEn), .actMode(actMode), .actGainFlat(actGainFlat)
);

// File: tb/pixgain_steer_tb.sv
module pixgain_steer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pixStrobe = 1'b0, hsync = 1'b0, vsync = 1'b0, wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [5:0] wrData = '0;
  logic [5:0] gainCode;
  logic [1:0] gainIdx;

  always #2 clk = ~clk;  // 250 MHz

  pixgain_steer dut_i (
    .clk(clk), .rstN(rstN), .pixStrobe(pixStrobe), .hsync(hsync), .vsync(vsync),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .gainCode(gainCode), .gainIdx(gainIdx)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [5:0] sg [4] = '{default: 6'd0};
  logic [5:0] ag [4] = '{default: 6'd0};
  logic sEn = 0, aEn = 0;
  logic [2:0] sMode = 0, aMode = 0;
  logic mPix = 0, mLine = 0, mField = 0, mPrevH = 0, mPrevV = 0;
  string scen = "";

  logic [5:0] expCode [$];
  logic [1:0] expIdx  [$];
  string      tagQ    [$];
  logic [5:0] lastCode = 0;
  logic [1:0] lastIdx = 0;

  task automatic tick(input logic s, input logic h, input logic v,
                      input logic we = 1'b0, input logic [2:0] a = 3'd0,
                      input logic [5:0] d = 6'd0);
    logic hE, vE;
    logic [1:0] idx;
    @(negedge clk);
    pixStrobe = s; hsync = h; vsync = v; wrEn = we; wrAddr = a; wrData = d;
    hE = h && !mPrevH;
    vE = v && !mPrevV;
    if (hE) begin
      for (int k = 0; k < 4; k++) ag[k] = sg[k];
      aEn = sEn; aMode = sMode; mPix = 0;
    end
    if (vE) mLine = 0; else if (hE) mLine = !mLine;
    if (vE) mField = !mField;
    if (s) begin
      if (!aEn) idx = 2'd0;
      else if (aMode == 3'd1) idx = {mLine, mPix};
      else if (aMode == 3'd2) idx = {mField, mPix};
      else idx = 2'd0;
      expIdx.push_back(idx);
      expCode.push_back(aEn ? ag[idx] : 6'h3F);
      if (scen != "") tagQ.push_back(scen);
      else if (!aEn) tagQ.push_back("R3");
      else if (aMode == 3'd1) tagQ.push_back("R5,R10");
      else if (aMode == 3'd2) tagQ.push_back("R6,R10");
      else tagQ.push_back("R4");
      mPix = !mPix;
    end
    mPrevH = h; mPrevV = v;
    if (we) begin
      if (a < 3'd4) sg[a[1:0]] = d;
      else if (a == 3'd4) begin sEn = d[3]; sMode = d[2:0]; end
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [5:0] d);
    tick(0, 0, 0, 1'b1, a, d);
  endtask

  task automatic pix(input int n);
    for (int i = 0; i < n; i++) tick(1, 0, 0);
  endtask

  task automatic hline(input int n);
    tick(0, 1, 0);
    pix(n);
  endtask

  task automatic frame(input int n);
    tick(0, 1, 1);
    pix(n);
  endtask

  // monitor / scoreboard
  logic capS = 0;
  always @(posedge clk) begin
    capS = pixStrobe;
    #1;
    if (rstN) begin
      if (capS) begin
        if (expCode.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2: output without expected item, got code=%h idx=%0d", gainCode, gainIdx);
        end else begin
          logic [5:0] c; logic [1:0] x; string t;
          c = expCode.pop_front(); x = expIdx.pop_front(); t = tagQ.pop_front();
          checks++;
          if (gainCode !== c || gainIdx !== x) begin
            fails++;
            $display("FAIL %s: code=%h idx=%0d expected code=%h idx=%0d", t, gainCode, gainIdx, c, x);
          end
          lastCode = c; lastIdx = x;
        end
      end else begin
        checks++;
        if (gainCode !== lastCode || gainIdx !== lastIdx) begin
          fails++;
          $display("FAIL R2: hold code=%h idx=%0d expected code=%h idx=%0d", gainCode, gainIdx, lastCode, lastIdx);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, got done=0 expected done=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (gainCode !== 6'd0 || gainIdx !== 2'd0) begin
      fails++;
      $display("FAIL R1: reset code=%h idx=%0d expected code=00 idx=0", gainCode, gainIdx);
    end
    // load gains and field mode; still disabled until HD
    wr(3'd0, 6'h05); wr(3'd1, 6'h1F); wr(3'd2, 6'h20); wr(3'd3, 6'h0A);
    wr(3'd4, 6'b001010);
    wr(3'd6, 6'h3F);  // ignored address (R9)
    scen = "R3"; pix(3);
    // R1: field flag still 0 after reset, only HD seen
    scen = "R1"; hline(4);
    // R5: mosaic across lines
    scen = ""; wr(3'd4, 6'b001001);
    hline(2);
    frame(4); hline(4); hline(3);
    // R6: field mode across two fields
    wr(3'd4, 6'b001010);
    hline(2);
    frame(3); hline(3);
    frame(3); hline(3);
    // R7: strobe in the HD edge cycle after an odd-length line
    wr(3'd4, 6'b001001);
    hline(3);
    scen = "R7"; tick(1, 1, 0); pix(2);
    tick(1, 1, 0); pix(2);
    // R8: VD alone mid-line clears line parity but not pixel parity
    scen = "R8"; tick(1, 0, 1); pix(2);
    tick(0, 0, 0); hline(2);
    // R9: write mid-line stays invisible until next HD
    scen = "R9"; wr(3'd0, 6'h12); wr(3'd1, 6'h2C); pix(2);
    frame(2);
    tick(0, 0, 0);
    // R9: pixel in HD edge cycle sees newly loaded bank
    wr(3'd2, 6'h33); scen = "R9"; tick(1, 1, 0); pix(1);
    // R4: fallback modes
    scen = ""; wr(3'd4, 6'b001101); hline(3);
    wr(3'd4, 6'b001000); hline(3);
    wr(3'd4, 6'b001111); frame(2);
    // R3: disable again
    wr(3'd4, 6'b000001); hline(3);
    tick(0, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule